// File: doc/BRIEF.md
# Register-Mapped GPIO Bank

This block is a general-purpose I/O controller for a bank of pins. The bank is reached over a simple 32-bit register bus with one-cycle write strobes and registered read data. Every pin owns two private 32-bit configuration words, placed 8 bytes apart. One word holds the output level, the sampled input level, the direction, the interrupt trigger shape and the mode choice between native function and GPIO. The other holds an input-sensing gate and a weak-pull selection.

State shared by a group of pins sits in bitmapped words, 32 pins per word. Pin n uses word n/32, bit n%32. There are three such bitmaps. The ownership bitmap is read-only and is loaded from a boot strap input while reset is held. The status bitmap is set by an external interrupt unit and cleared by software. The enable bitmap is read and written by software.

The block drives registered output levels and output enables to the pads. It carries pad inputs through a two-flop synchronizer. It does not raise interrupts itself. It hands each pin's gated input level, trigger settings and enable to a separate interrupt unit.

Top module: `gpio_bank`

## Requirements
- R1: After reset every pad output enable is 0, every first config word reads 0x00000004 (direction = input, use = native), every second config word reads 0x00000004 (sensing disabled, pull 0), and the status and enable bitmaps read 0.
- R2: The ownership bitmap occupies words 0x00, 0x04 and 0x08. It holds the value of `boot_own_map` captured while `rst` is high. A 0 bit marks a pin reserved for firmware. Bus writes to these words have no effect.
- R3: The first config word of pin n is at 0x100+8n. Its fields are bit 31 output level, bit 4 level trigger, bit 3 invert, bit 2 direction (1 = input) and bit 0 use (1 = GPIO). All other bits read 0 except bit 30. Bit 30 cannot be written. Bits 4 and 3 drive `irq_trig_lvl[n]` and `irq_invert[n]`.
- R4: The second config word of pin n is at 0x104+8n. Bit 2 disables input sensing and bits 1:0 select the weak pull. The pull bits drive `pad_pull[2n+1:2n]`. All other bits read 0.
- R5: A pin is in GPIO mode when it is owned and its use bit is 1. In that mode `pad_oe` equals the inverse of the direction bit and `pad_out` equals the output level bit. Both pad outputs update on the clock edge after the config write.
- R6: A pin not in GPIO mode passes `nat_out` and `nat_oe` to its pad with one cycle of register delay. This also holds for a pin whose ownership bit is 0, even when its use bit is 1.
- R7: Bit 30 of the first config word and `irq_level[n]` show the synchronized pad input when sensing is enabled. The synchronizer is two flops. Both read 0 while bit 2 of the second word is 1.
- R8: The status bitmap is at 0x80, 0x84 and 0x88. A 1 on `irq_event[n]` sets bit n. Writing 1 to a bit clears it and writing 0 leaves it alone. An event in the same cycle as a clear leaves the bit set.
- R9: The enable bitmap is at 0x90, 0x94 and 0x98. It is read/write and drives `irq_en`. Bits above the pin count read 0 in every bitmap.
- R10: Reads of unmapped addresses return 0. Writes to unmapped addresses change no state.
- R11: `bus_rdata` is loaded on the clock edge where `bus_rd` is 1 and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_own_map | input | NUM_PINS | Ownership strap, captured during reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | NUM_PINS | Asynchronous pad inputs |
| pad_out | output | NUM_PINS | Pad output levels |
| pad_oe | output | NUM_PINS | Pad output enables |
| pad_pull | output | 2*NUM_PINS | Weak-pull selection per pin |
| nat_out | input | NUM_PINS | Native-function output levels |
| nat_oe | input | NUM_PINS | Native-function output enables |
| irq_event | input | NUM_PINS | Status set pulses from the interrupt unit |
| irq_level | output | NUM_PINS | Gated synchronized input level per pin |
| irq_en | output | NUM_PINS | Enable bitmap |
| irq_trig_lvl | output | NUM_PINS | Level-trigger bit per pin |
| irq_invert | output | NUM_PINS | Invert bit per pin |

## Verification
The hardest case to reach from the ports is the collision in the status bitmap. A set pulse and a write-one clear land on the same bit in the same clock. The bench drives the event line and the write strobe together at one falling edge, then reads the word back to confirm the bit survives. A second hard case is a pin whose ownership bit is 0. The bench loads a strap with holes at pins 5 and 93 during reset, writes GPIO mode into pin 5 and checks that its pad still follows the native inputs.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int DATA_W     = 32;
  localparam int OFS_OWN    = 'h000;
  localparam int OFS_STAT   = 'h080;
  localparam int OFS_EN     = 'h090;
  localparam int OFS_CFG    = 'h100;
  localparam int CFG_STRIDE = 8;

  localparam int C1_OUT  = 31;
  localparam int C1_IN   = 30;
  localparam int C1_TRIG = 4;
  localparam int C1_INV  = 3;
  localparam int C1_DIR  = 2;
  localparam int C1_USE  = 0;
  localparam int C2_DIS  = 2;

  typedef struct packed {
    logic       out_lvl;
    logic       trig_lvl;
    logic       invert;
    logic       dir_in;
    logic       use_gpio;
    logic       in_dis;
    logic [1:0] pull;
  } pin_cfg_t;

  localparam pin_cfg_t CFG_RESET = '{out_lvl: 1'b0, trig_lvl: 1'b0, invert: 1'b0,
                                     dir_in: 1'b1, use_gpio: 1'b0, in_dis: 1'b1,
                                     pull: 2'b00};
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage[s] <= '0;
    end else begin
      stage[0] <= d;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_bank_pin.sv
module gpio_bank_pin
  import gpio_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr1,
  input  logic              wr2,
  input  logic [DATA_W-1:0] wdata,
  input  logic              in_sync,
  input  logic              owned,
  input  logic              nat_out,
  input  logic              nat_oe,
  output logic [DATA_W-1:0] word1,
  output logic [DATA_W-1:0] word2,
  output logic              pad_out,
  output logic              pad_oe,
  output logic [1:0]        pull,
  output logic              level,
  output logic              trig_lvl,
  output logic              invert
);
  pin_cfg_t cfg;
  logic     gpio_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= CFG_RESET;
    end else begin
      if (wr1) begin
        cfg.out_lvl  <= wdata[C1_OUT];
        cfg.trig_lvl <= wdata[C1_TRIG];
        cfg.invert   <= wdata[C1_INV];
        cfg.dir_in   <= wdata[C1_DIR];
        cfg.use_gpio <= wdata[C1_USE];
      end
      if (wr2) begin
        cfg.in_dis <= wdata[C2_DIS];
        cfg.pull   <= wdata[1:0];
      end
    end
  end

  assign gpio_mode = cfg.use_gpio & owned;
  assign level     = in_sync & ~cfg.in_dis;

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= 1'b0;
      pad_oe  <= 1'b0;
    end else begin
      pad_out <= gpio_mode ? cfg.out_lvl : nat_out;
      pad_oe  <= gpio_mode ? ~cfg.dir_in : nat_oe;
    end
  end

  always_comb begin
    word1          = '0;
    word1[C1_OUT]  = cfg.out_lvl;
    word1[C1_IN]   = level;
    word1[C1_TRIG] = cfg.trig_lvl;
    word1[C1_INV]  = cfg.invert;
    word1[C1_DIR]  = cfg.dir_in;
    word1[C1_USE]  = cfg.use_gpio;
    word2          = '0;
    word2[C2_DIS]  = cfg.in_dis;
    word2[1:0]     = cfg.pull;
  end

  assign pull     = cfg.pull;
  assign trig_lvl = cfg.trig_lvl;
  assign invert   = cfg.invert;
endmodule

// File: rtl/gpio_bank_group.sv
module gpio_bank_group
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 94,
  parameter int NW       = 3,
  parameter int WIDX_W   = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PINS-1:0]  boot_own,
  input  logic                 wr_stat,
  input  logic                 wr_en,
  input  logic [WIDX_W-1:0]    widx,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [NUM_PINS-1:0]  event_in,
  output logic [NUM_PINS-1:0]  own_q,
  output logic [NUM_PINS-1:0]  stat_q,
  output logic [NUM_PINS-1:0]  en_q,
  output logic [NW*DATA_W-1:0] own_pad,
  output logic [NW*DATA_W-1:0] stat_pad,
  output logic [NW*DATA_W-1:0] en_pad
);
  always_ff @(posedge clk) begin
    if (rst) begin
      own_q  <= boot_own;
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      for (int i = 0; i < NUM_PINS; i++) begin
        if (wr_en && widx == WIDX_W'(i / DATA_W))
          en_q[i] <= wdata[i % DATA_W];
        if (event_in[i])
          stat_q[i] <= 1'b1;
        else if (wr_stat && widx == WIDX_W'(i / DATA_W) && wdata[i % DATA_W])
          stat_q[i] <= 1'b0;
      end
    end
  end

  assign own_pad  = (NW*DATA_W)'(own_q);
  assign stat_pad = (NW*DATA_W)'(stat_q);
  assign en_pad   = (NW*DATA_W)'(en_q);
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 94,
  parameter int ADDR_W   = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_PINS-1:0]   boot_own_map,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic [NUM_PINS-1:0]   pad_in,
  output logic [NUM_PINS-1:0]   pad_out,
  output logic [NUM_PINS-1:0]   pad_oe,
  output logic [2*NUM_PINS-1:0] pad_pull,
  input  logic [NUM_PINS-1:0]   nat_out,
  input  logic [NUM_PINS-1:0]   nat_oe,
  input  logic [NUM_PINS-1:0]   irq_event,
  output logic [NUM_PINS-1:0]   irq_level,
  output logic [NUM_PINS-1:0]   irq_en,
  output logic [NUM_PINS-1:0]   irq_trig_lvl,
  output logic [NUM_PINS-1:0]   irq_invert
);
  localparam int NW       = (NUM_PINS + DATA_W - 1) / DATA_W;
  localparam int WIDX_W   = (NW > 1) ? $clog2(NW) : 1;
  localparam int PIDX_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
  localparam int STAT_WA  = OFS_STAT / 4;
  localparam int EN_WA    = OFS_EN / 4;
  localparam int CFG_END  = OFS_CFG + CFG_STRIDE * NUM_PINS;

  logic [31:0]         a32;
  logic [31:0]         wa;
  logic                own_hit, stat_hit, en_hit, cfg_hit, sel2;
  logic [WIDX_W-1:0]   gidx;
  logic [PIDX_W-1:0]   pin_idx;
  logic [NUM_PINS-1:0] in_sync;
  logic [NUM_PINS-1:0] own_vec, stat_vec;
  logic [NW*DATA_W-1:0] own_pad, stat_pad, en_pad;
  logic [DATA_W-1:0]   word1 [NUM_PINS];
  logic [DATA_W-1:0]   word2 [NUM_PINS];
  logic [DATA_W-1:0]   rd_val;

  // address decode
  assign a32      = 32'(bus_addr);
  assign wa       = a32 >> 2;
  assign own_hit  = (wa < 32'(NW));
  assign stat_hit = (wa >= 32'(STAT_WA)) && (wa < 32'(STAT_WA + NW));
  assign en_hit   = (wa >= 32'(EN_WA)) && (wa < 32'(EN_WA + NW));
  assign cfg_hit  = (a32 >= 32'(OFS_CFG)) && (a32 < 32'(CFG_END));
  assign sel2     = bus_addr[2];
  assign pin_idx  = PIDX_W'((a32 - 32'(OFS_CFG)) >> 3);

  always_comb begin
    if (stat_hit)      gidx = WIDX_W'(wa - 32'(STAT_WA));
    else if (en_hit)   gidx = WIDX_W'(wa - 32'(EN_WA));
    else               gidx = WIDX_W'(wa);
  end

  gpio_bank_sync #(.W(NUM_PINS), .STAGES(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (in_sync)
  );

  gpio_bank_group #(.NUM_PINS(NUM_PINS), .NW(NW), .WIDX_W(WIDX_W)) u_group (
    .clk      (clk),
    .rst      (rst),
    .boot_own (boot_own_map),
    .wr_stat  (bus_wr & stat_hit),
    .wr_en    (bus_wr & en_hit),
    .widx     (gidx),
    .wdata    (bus_wdata),
    .event_in (irq_event),
    .own_q    (own_vec),
    .stat_q   (stat_vec),
    .en_q     (irq_en),
    .own_pad  (own_pad),
    .stat_pad (stat_pad),
    .en_pad   (en_pad)
  );

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    logic hit_n;
    assign hit_n = bus_wr & cfg_hit & (pin_idx == PIDX_W'(n));

    gpio_bank_pin u_pin (
      .clk      (clk),
      .rst      (rst),
      .wr1      (hit_n & ~sel2),
      .wr2      (hit_n & sel2),
      .wdata    (bus_wdata),
      .in_sync  (in_sync[n]),
      .owned    (own_vec[n]),
      .nat_out  (nat_out[n]),
      .nat_oe   (nat_oe[n]),
      .word1    (word1[n]),
      .word2    (word2[n]),
      .pad_out  (pad_out[n]),
      .pad_oe   (pad_oe[n]),
      .pull     (pad_pull[2*n +: 2]),
      .level    (irq_level[n]),
      .trig_lvl (irq_trig_lvl[n]),
      .invert   (irq_invert[n])
    );
  end

  // read path
  always_comb begin
    rd_val = '0;
    if (own_hit)       rd_val = own_pad[gidx*DATA_W +: DATA_W];
    else if (stat_hit) rd_val = stat_pad[gidx*DATA_W +: DATA_W];
    else if (en_hit)   rd_val = en_pad[gidx*DATA_W +: DATA_W];
    else if (cfg_hit)  rd_val = sel2 ? word2[pin_idx] : word1[pin_idx];
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int NUM_PINS = 94,
  parameter int ADDR_W   = 12
) (
  input logic                clk,
  input logic                rst,
  input logic                bus_rd,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [31:0]         bus_rdata,
  input logic [NUM_PINS-1:0] nat_oe,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic [NUM_PINS-1:0] own_vec,
  input logic [NUM_PINS-1:0] irq_event,
  input logic [NUM_PINS-1:0] stat_vec
);
  localparam int GW = (NUM_PINS + 31) / 32;
  logic pv;
  logic unmapped;
  int   a;

  always_ff @(posedge clk) pv <= !rst;

  always_comb begin
    a = int'(bus_addr);
    unmapped = !((a < 4*GW) || (a >= 'h80 && a < 'h80 + 4*GW) ||
                 (a >= 'h90 && a < 'h90 + 4*GW) ||
                 (a >= 'h100 && a < 'h100 + 8*NUM_PINS));
  end

  p_own_stable_r2: assert property (@(posedge clk) disable iff (rst)
    pv |-> $stable(own_vec));

  p_native_oe_r6: assert property (@(posedge clk) disable iff (rst)
    pv |-> ((pad_oe & ~own_vec) == ($past(nat_oe) & ~own_vec)));

  p_event_sets_r8: assert property (@(posedge clk) disable iff (rst)
    pv |-> (($past(irq_event) & ~stat_vec) == '0));

  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (pv && $past(bus_rd) && $past(unmapped)) |-> (bus_rdata == 32'h0));

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (pv && !$past(bus_rd)) |-> $stable(bus_rdata));
endmodule

bind gpio_bank gpio_bank_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .nat_oe    (nat_oe),
  .pad_oe    (pad_oe),
  .own_vec   (own_vec),
  .irq_event (irq_event),
  .stat_vec  (stat_vec)
);

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;
  localparam int N = 94;
  localparam int AW = 12;

  logic clk = 0, rst = 1;
  logic [N-1:0] boot_own_map, pad_in, nat_out, nat_oe, irq_event;
  logic bus_wr = 0, bus_rd = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [N-1:0] pad_out, pad_oe, irq_level, irq_en, irq_trig_lvl, irq_invert;
  logic [2*N-1:0] pad_pull;

  int checks = 0, fails = 0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sb[$];

  gpio_bank #(.NUM_PINS(N), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .boot_own_map(boot_own_map),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull(pad_pull),
    .nat_out(nat_out), .nat_oe(nat_oe), .irq_event(irq_event),
    .irq_level(irq_level), .irq_en(irq_en),
    .irq_trig_lvl(irq_trig_lvl), .irq_invert(irq_invert)
  );

  always #4 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(int addr, logic [31:0] data);
    @(negedge clk);
    bus_wr = 1; bus_addr = AW'(addr); bus_wdata = data;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(int addr, logic [31:0] exp, string tag);
    item_t it;
    it.exp = exp; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    bus_rd = 1; bus_addr = AW'(addr);
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops one expected item per read strobe
  initial begin
    forever begin
      @(posedge clk);
      if (bus_rd) begin
        @(negedge clk);
        if (sb.size() == 0) chk("scoreboard empty", 32'h1, 32'h0);
        else begin
          item_t it;
          it = sb.pop_front();
          chk(it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    boot_own_map = ~((N'(1) << 5) | (N'(1) << 93));
    pad_in = '0; nat_out = '0; nat_oe = '0; irq_event = '0;
    repeat (5) @(posedge clk);
    @(negedge clk); rst = 0;
    idle(2);

    // R1 reset state
    chk("R1 pad_oe low", 32'(pad_oe != '0), 32'h0);
    rd('h100, 32'h4, "R1 cfg1 pin0");
    rd('h104 + 8*93, 32'h4, "R1 cfg2 pin93");
    rd('h090, 32'h0, "R1 enable word0");
    rd('h088, 32'h0, "R1 status word2");

    // R2 ownership bitmap, write ignored
    rd('h000, 32'hFFFF_FFDF, "R2 own word0");
    rd('h004, 32'hFFFF_FFFF, "R2 own word1");
    rd('h008, 32'h1FFF_FFFF, "R2 own word2");
    wr('h000, 32'h0);
    rd('h000, 32'hFFFF_FFDF, "R2 own write ignored");

    // R3 cfg1 fields
    wr('h100 + 8*3, 32'hFFFF_FFFF);
    rd('h100 + 8*3, 32'h8000_001D, "R3 cfg1 pin3 fields");
    idle(1);
    chk("R3 trig pin3", 32'(irq_trig_lvl[3]), 32'h1);
    chk("R3 invert pin3", 32'(irq_invert[3]), 32'h1);

    // R4 cfg2 fields
    wr('h104 + 8*20, 32'hFFFF_FFFF);
    rd('h104 + 8*20, 32'h7, "R4 cfg2 pin20");
    chk("R4 pull pin20", 32'(pad_pull[41:40]), 32'h3);

    // R5 GPIO drive
    wr('h100 + 8*7, 32'h8000_0001);
    idle(1);
    chk("R5 oe pin7", 32'(pad_oe[7]), 32'h1);
    chk("R5 out pin7 high", 32'(pad_out[7]), 32'h1);
    wr('h100 + 8*7, 32'h0000_0001);
    idle(1);
    chk("R5 out pin7 low", 32'(pad_out[7]), 32'h0);
    wr('h100 + 8*7, 32'h0000_0005);
    idle(1);
    chk("R5 oe pin7 input", 32'(pad_oe[7]), 32'h0);

    // R6 native pass-through, including a non-owned pin
    @(negedge clk); nat_oe[8] = 1; nat_out[8] = 1;
    idle(2);
    chk("R6 native oe pin8", 32'(pad_oe[8]), 32'h1);
    chk("R6 native out pin8", 32'(pad_out[8]), 32'h1);
    wr('h100 + 8*5, 32'h8000_0001);
    idle(1);
    chk("R6 unowned pin5 oe", 32'(pad_oe[5]), 32'h0);
    @(negedge clk); nat_oe[5] = 1; nat_out[5] = 0;
    idle(2);
    chk("R6 unowned pin5 native oe", 32'(pad_oe[5]), 32'h1);
    chk("R6 unowned pin5 native out", 32'(pad_out[5]), 32'h0);

    // R7 input sensing
    @(negedge clk); pad_in[10] = 1;
    idle(3);
    rd('h100 + 8*10, 32'h0000_0004, "R7 sensing disabled reads 0");
    wr('h104 + 8*10, 32'h0);
    idle(1);
    rd('h100 + 8*10, 32'h4000_0004, "R7 sensing enabled");
    chk("R7 irq_level pin10", 32'(irq_level[10]), 32'h1);
    wr('h104 + 8*10, 32'h4);
    idle(1);
    chk("R7 irq_level gated", 32'(irq_level[10]), 32'h0);

    // R8 status set / clear / collision
    @(negedge clk); irq_event[33] = 1;
    @(negedge clk); irq_event[33] = 0;
    rd('h084, 32'h2, "R8 status set");
    wr('h084, 32'h0);
    rd('h084, 32'h2, "R8 write 0 keeps");
    wr('h084, 32'h2);
    rd('h084, 32'h0, "R8 write 1 clears");
    @(negedge clk);
    irq_event[33] = 1; bus_wr = 1; bus_addr = AW'('h084); bus_wdata = 32'h2;
    @(negedge clk);
    irq_event[33] = 0; bus_wr = 0;
    rd('h084, 32'h2, "R8 set wins over clear");

    // R9 enable bitmap
    wr('h098, 32'hFFFF_FFFF);
    rd('h098, 32'h3FFF_FFFF, "R9 enable word2 masked");
    chk("R9 irq_en pin93", 32'(irq_en[93]), 32'h1);
    chk("R9 irq_en pin63", 32'(irq_en[63]), 32'h0);

    // R10 unmapped
    rd('h040, 32'h0, "R10 unmapped 0x040");
    rd('h3F0, 32'h0, "R10 unmapped 0x3F0");
    wr('h00C, 32'hFFFF_FFFF);
    wr('h09C, 32'hFFFF_FFFF);
    rd('h090, 32'h0, "R10 enable untouched");
    rd('h00C, 32'h0, "R10 unmapped 0x00C");

    // R11 rdata holds without read strobe
    rd('h004, 32'hFFFF_FFFF, "R11 load");
    @(negedge clk); bus_addr = AW'('h090);
    idle(2);
    chk("R11 rdata hold", bus_rdata, 32'hFFFF_FFFF);

    idle(3);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule